// File: doc/BRIEF.md
# Three-Requester Hold Arbiter

This block lets three clients share a single resource. Each client raises its own request line. When the unit is free, it picks one winner by fixed priority and raises that client's grant line. The lowest-indexed request wins, so bit 0 beats bit 1 and bit 1 beats bit 2. The winner keeps the resource for as long as it holds its request high. Other requests cannot take the grant away, not even a higher-priority one. When the winner drops its request, the unit passes through one free cycle and then arbitrates again among whoever is still waiting.

The grant outputs are Moore outputs. They are decoded only from the registered state, so a change on a request input reaches the grant on the next clock edge and never within the same cycle. The state register can be built as a one-hot or a binary register, selected by a parameter. Both builds give the same sequence of grants at the ports.

Top module: `arb3_hold_arbiter`

## Requirements
- R1: A high `rst` sampled at a rising clock edge forces the free state, so `grant` is 3'b000 after that edge, whatever `req` is.
- R2: From the free state, the grant appears one edge after the requests are sampled. `req[0]` yields `grant`=3'b001. Otherwise `req[1]` yields 3'b010. Otherwise `req[2]` yields 3'b100.
- R3: In the free state with `req`=3'b000, the block stays free and `grant` stays 3'b000.
- R4: While the owner's request bit stays high, `grant` keeps the same value.
- R5: While a grant is held, the other request bits have no effect on `grant`, including higher-priority ones.
- R6: When the owner's request bit is low at an edge, `grant` becomes 3'b000 for the next cycle, even if other requests are pending.
- R7: A requester still waiting after a release receives its grant one edge after the free cycle, chosen by the priority of R2.
- R8: At most one bit of `grant` is high in any cycle.
- R9: The one-hot build (`ONE_HOT`=1) and the binary build (`ONE_HOT`=0) produce identical `grant` sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request lines; bit 0 has highest priority |
| grant | output | 3 | Grant lines, at most one high, decoded from state |

## Verification
On every cycle, the bound checker enforces the following: the transition out of the free state follows the priority order, the free state is held when no request is present, a held grant stays stable while its owner keeps requesting, a release is always followed by a free cycle, and at most one grant bit is high. Some behaviours can only be shown by the directed scenarios. These are the waiting client being served right after the free cycle, a high-priority request arriving mid-hold and being ignored, a reset arriving in the middle of a grant, and the cycle-by-cycle agreement between the one-hot and binary builds running side by side.

// File: rtl/arb3_pkg.sv
package arb3_pkg;

  localparam int unsigned NCLI = 3;
  localparam int unsigned NST  = NCLI + 1;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_OWN0  = 2'd1,
    ST_OWN1  = 2'd2,
    ST_OWN2  = 2'd3
  } arb_st_e;

  // Winner chosen from the free state: lowest index first.
  function automatic arb_st_e pick_owner(input logic [NCLI-1:0] r);
    arb_st_e s;
    s = ST_FREE;
    for (int k = NCLI - 1; k >= 0; k--) begin
      if (r[k]) s = arb_st_e'(k + 1);
    end
    return s;
  endfunction

  // Index of the owning client for a held state.
  function automatic int unsigned owner_idx(input arb_st_e s);
    return (s == ST_FREE) ? 0 : int'(s) - 1;
  endfunction

  function automatic logic [NCLI-1:0] grant_of(input arb_st_e s);
    logic [NCLI-1:0] g;
    g = '0;
    if (s != ST_FREE) g[owner_idx(s)] = 1'b1;
    return g;
  endfunction

  function automatic logic [NST-1:0] to_onehot(input arb_st_e s);
    logic [NST-1:0] v;
    v = '0;
    v[int'(s)] = 1'b1;
    return v;
  endfunction

  function automatic arb_st_e from_onehot(input logic [NST-1:0] v);
    arb_st_e s;
    s = ST_FREE;
    for (int k = 1; k < NST; k++) begin
      if (v[k]) s = arb_st_e'(k);
    end
    return s;
  endfunction

endpackage

// File: rtl/arb3_next_state.sv
module arb3_next_state
  import arb3_pkg::*;
(
  input  arb_st_e          cur,
  input  logic [NCLI-1:0]  req,
  output arb_st_e          nxt
);

  logic owner_keeps;

  always_comb begin
    owner_keeps = 1'b0;
    if (cur != ST_FREE) owner_keeps = req[owner_idx(cur)];
  end

  always_comb begin
    if (cur == ST_FREE) nxt = pick_owner(req);
    else if (owner_keeps) nxt = cur;
    else nxt = ST_FREE;
  end

endmodule

// File: rtl/arb3_state_reg.sv
module arb3_state_reg
  import arb3_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  arb_st_e d,
  output arb_st_e q
);

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NST-1:0] oh_q;
      always_ff @(posedge clk) begin
        if (rst) oh_q <= to_onehot(ST_FREE);
        else     oh_q <= to_onehot(d);
      end
      assign q = from_onehot(oh_q);
    end else begin : g_binary
      arb_st_e bin_q;
      always_ff @(posedge clk) begin
        if (rst) bin_q <= ST_FREE;
        else     bin_q <= d;
      end
      assign q = bin_q;
    end
  endgenerate

endmodule

// File: rtl/arb3_grant_decode.sv
module arb3_grant_decode
  import arb3_pkg::*;
(
  input  arb_st_e         st,
  output logic [NCLI-1:0] grant
);

  assign grant = grant_of(st);

endmodule

// File: rtl/arb3_hold_arbiter.sv
module arb3_hold_arbiter
  import arb3_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req,
  output logic [2:0] grant
);

  arb_st_e st_cur;
  arb_st_e st_nxt;

  // Named events for the checker.
  logic ev_launch;
  logic ev_release;

  arb3_next_state u_next (
    .cur (st_cur),
    .req (req),
    .nxt (st_nxt)
  );

  arb3_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (st_nxt),
    .q   (st_cur)
  );

  arb3_grant_decode u_dec (
    .st    (st_cur),
    .grant (grant)
  );

  assign ev_launch  = (st_cur == ST_FREE) && (st_nxt != ST_FREE);
  assign ev_release = (st_cur != ST_FREE) && (st_nxt == ST_FREE);

endmodule

// File: rtl/arb3_checker.sv
module arb3_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] req,
  input logic [2:0] grant,
  input logic       ev_launch,
  input logic       ev_release
);

  AST_RESET_FREE: assert property (@(posedge clk) rst |=> (grant == 3'b000)); // R1

  AST_PRIO_FIRST: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req[0]) |=> (grant == 3'b001)); // R2

  AST_PRIO_SECOND: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && !req[0] && req[1]) |=> (grant == 3'b010)); // R2

  AST_PRIO_THIRD: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req == 3'b100) |=> (grant == 3'b100)); // R2

  AST_STAY_FREE: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req == 3'b000) |=> (grant == 3'b000)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((grant & req) != 3'b000) |=> $stable(grant)); // R4

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    (grant != 3'b000 && (grant & req) == 3'b000) |=> (grant == 3'b000)); // R6

  AST_LAUNCH_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    ev_launch |-> (grant == 3'b000 && req != 3'b000)); // R2

  AST_RELEASE_EVENT: assert property (@(posedge clk) disable iff (rst)
    ev_release |-> (grant != 3'b000 && (grant & req) == 3'b000)); // R6

  AST_AT_MOST_ONE: assert property (@(posedge clk) $onehot0(grant)); // R8

endmodule

bind arb3_hold_arbiter arb3_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .grant      (grant),
  .ev_launch  (ev_launch),
  .ev_release (ev_release)
);

// File: tb/sim_arb3_hold_arbiter.sv
`timescale 1ns/1ps
module sim_arb3_hold_arbiter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = 3'b000;
  logic [2:0] g_oh;
  logic [2:0] g_bin;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  arb3_hold_arbiter #(.ONE_HOT(1'b1)) u0 (.clk(clk), .rst(rst), .req(req), .grant(g_oh));
  arb3_hold_arbiter #(.ONE_HOT(1'b0)) u1 (.clk(clk), .rst(rst), .req(req), .grant(g_bin));

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample after it.
  task automatic step(input logic r_rst, input logic [2:0] r, input string tag,
                      input logic [2:0] exp);
    @(negedge clk);
    rst = r_rst;
    req = r;
    @(posedge clk);
    #1;
    check(tag, g_oh, exp);
    check("R9 encodings agree", g_bin, g_oh);
  endtask

  task automatic t_reset();
    step(1'b1, 3'b111, "R1 reset with all requests", 3'b000);
    step(1'b1, 3'b001, "R1 reset held", 3'b000);
  endtask

  task automatic t_idle();
    step(1'b0, 3'b000, "R3 stays free", 3'b000);
    step(1'b0, 3'b000, "R3 stays free again", 3'b000);
  endtask

  task automatic t_priority();
    logic [2:0] pats [7] = '{3'b111, 3'b110, 3'b100, 3'b101, 3'b011, 3'b010, 3'b001};
    logic [2:0] wins [7] = '{3'b001, 3'b010, 3'b100, 3'b001, 3'b001, 3'b010, 3'b001};
    for (int i = 0; i < 7; i++) begin
      step(1'b0, pats[i], "R2 priority winner", wins[i]);
      step(1'b0, 3'b000, "R6 release to free", 3'b000);
    end
  endtask

  task automatic t_hold_and_pass();
    step(1'b0, 3'b100, "R2 low client wins", 3'b100);
    step(1'b0, 3'b111, "R5 higher requests ignored", 3'b100);
    step(1'b0, 3'b101, "R4 grant held", 3'b100);
    step(1'b0, 3'b011, "R6 free cycle with waiters", 3'b000);
    step(1'b0, 3'b011, "R7 waiter served by priority", 3'b001);
    step(1'b0, 3'b010, "R6 free cycle after release", 3'b000);
    step(1'b0, 3'b010, "R7 remaining waiter served", 3'b010);
    step(1'b0, 3'b011, "R5 top request ignored", 3'b010);
    step(1'b0, 3'b000, "R6 release", 3'b000);
  endtask

  task automatic t_reset_midgrant();
    step(1'b0, 3'b010, "R2 grant before reset", 3'b010);
    step(1'b1, 3'b010, "R1 reset overrides held grant", 3'b000);
    step(1'b0, 3'b010, "R2 regrant after reset", 3'b010);
    step(1'b0, 3'b000, "R6 release", 3'b000);
  endtask

  initial begin
    #1;
    check("R1 state before first edge matches", g_bin, g_oh);
    t_reset();
    t_idle();
    t_priority();
    t_hold_and_pass();
    t_reset_midgrant();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: grant=%b expected=completion", g_oh);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule